// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block serves one DMA channel running in block transfer mode, started by an active-low request pin. Software arms the channel with a one-cycle enable strobe. The strobe loads the start addresses of the source and the destination, the number of read/write pairs in each block, and the number of blocks. After that, every low level the block samples on the request pin moves exactly one block. The block requests the bus and waits for the grant. It then alternates source reads with destination writes and finishes with one dead cycle. The bus is handed back in the idle cycle that follows.

The request pin passes through a synchronizer before it is sampled. A sampled low level is held as a pending request until the channel activates. While a block is being moved, the pin is not looked at again until its dead cycle has finished. A pin that stays low therefore starts one block per pass, and never more than one. When the last block's dead cycle ends, the channel disarms itself and gives a one-cycle completion pulse.

Top module: `lvl_dma_seq`

## Requirements
- R1: Pin sampling begins on the clock edge after the edge that takes the enable strobe. When the pin has been low for at least the synchronizer depth and the grant is immediate, the cycle after that edge is idle, the next is bus release, and the third is the first read.
- R2: A low synchronized pin level sampled while the channel is armed and idle sets a held request. A high level never starts a block.
- R3: The held request clears on the edge where the channel activates, which is the edge where the phase leaves idle for bus release.
- R4: One block is `cfg_size` read phases, each followed at once by a write phase, and then exactly one dead phase.
- R5: Sampling is closed from activation until the dead phase ends. A low pulse that falls wholly inside a transfer starts nothing. A pin held low with an immediate grant gives a read exactly 4 cycles after each non-final dead phase.
- R6: Source and destination addresses load at the enable strobe and step by UNIT after each read and each write respectively. `addr` shows the source address during read and the destination address otherwise.
- R7: At least two cycles pass from the sampling edge to the first read. Bus release is one of them.
- R8: `bus_req` is high from bus release through dead and low in idle. Bus release holds until `bus_gnt` is high.
- R9: After `cfg_count` blocks, `busy` drops and `done` pulses for one cycle. No further block starts even if the pin stays low.
- R10: The enable strobe is ignored while `busy` is high, and also when `cfg_size` or `cfg_count` is zero.
- R11: The phase encoding is idle=0, release=1, read=2, write=3, dead=4. After reset the phase is idle and `bus_req`, `rd_stb`, `wr_stb`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | One-cycle strobe that arms the channel |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_size | input | SZ_W | Read/write pairs per block |
| cfg_count | input | CNT_W | Blocks per transfer |
| dreq_n | input | 1 | Asynchronous active-low request pin |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| phase | output | 3 | Current phase code |
| rd_stb | output | 1 | Source read strobe |
| wr_stb | output | 1 | Destination write strobe |
| addr | output | AW | Address of the current access |
| busy | output | 1 | Channel armed |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two events can fall on the same edge: the activation that clears the held request, and a fresh low sample of a pin still held low. Activation must win, or a second block would be queued behind the first. Holding the pin low through whole transfers provokes this on every pass. The result is judged by the number of dead phases, which must equal `cfg_count`, and by the exact 4-cycle gap from dead to the next read. Randomly toggled pin levels and random grant delays exercise the same collision at shifted offsets, and each run is checked against addresses and per-block read counts computed in the bench.

// File: rtl/lds_pkg.sv
package lds_pkg;
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_RELEASE = 3'd1,
      PH_READ    = 3'd2,
      PH_WRITE   = 3'd3,
      PH_DEAD    = 3'd4
   } phase_e;
endpackage

// File: rtl/lds_sync.sv
module lds_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lds_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], din};
   end

   assign dout = sh[STAGES-1];
endmodule

// File: rtl/lds_accept.sv
module lds_accept (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic lvl_n_i,
   input  logic act_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend_o <= 1'b0;
      else if (act_i)              pend_o <= 1'b0;
      else if (open_i && !lvl_n_i) pend_o <= 1'b1;
   end
endmodule

// File: rtl/lds_ptrs.sv
module lds_ptrs #(
   parameter int AW   = 16,
   parameter int UNIT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] src_base_i,
   input  logic [AW-1:0] dst_base_i,
   input  logic          rd_i,
   input  logic          wr_i,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o
);
   localparam logic [AW-1:0] STEP = AW'(UNIT);

   generate
      if (UNIT < 1) begin : g_bad_unit
         $error("lds_ptrs: UNIT must be positive");
      end
      for (genvar i = 0; i < 2; i++) begin : g_ptr
         logic [AW-1:0] q;
         logic          step;
         logic [AW-1:0] base;
         if (i == 0) begin : g_src
            assign step  = rd_i;
            assign base  = src_base_i;
            assign src_o = q;
         end else begin : g_dst
            assign step  = wr_i;
            assign base  = dst_base_i;
            assign dst_o = q;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (load_i) q <= base;
            else if (step)   q <= q + STEP;
         end
      end
   endgenerate
endmodule

// File: rtl/lds_fsm.sv
module lds_fsm
   import lds_pkg::*;
#(
   parameter int SZ_W  = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr_i,
   input  logic [SZ_W-1:0]  cfg_size_i,
   input  logic [CNT_W-1:0] cfg_count_i,
   input  logic             pend_i,
   input  logic             bus_gnt_i,
   output phase_e           phase_o,
   output logic             load_o,
   output logic             open_o,
   output logic             act_o,
   output logic             busy_o,
   output logic             done_o
);
   generate
      if (SZ_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("lds_fsm: counter widths must be positive");
      end
   endgenerate

   localparam logic [SZ_W-1:0]  SZ_ONE  = SZ_W'(1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   phase_e             state;
   logic               ch_en;
   logic               done_q;
   logic [SZ_W-1:0]    size_cfg;
   logic [SZ_W-1:0]    size_rem;
   logic [CNT_W-1:0]   blk_rem;

   assign load_o  = en_wr_i && !ch_en && (cfg_size_i != '0) && (cfg_count_i != '0);
   assign open_o  = ch_en && (state == PH_IDLE);
   assign act_o   = open_o && pend_i;
   assign busy_o  = ch_en;
   assign done_o  = done_q;
   assign phase_o = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PH_IDLE;
         ch_en    <= 1'b0;
         done_q   <= 1'b0;
         size_cfg <= '0;
         size_rem <= '0;
         blk_rem  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            ch_en    <= 1'b1;
            size_cfg <= cfg_size_i;
            blk_rem  <= cfg_count_i;
         end
         unique case (state)
            PH_IDLE: begin
               if (act_o) begin
                  state    <= PH_RELEASE;
                  size_rem <= size_cfg;
               end
            end
            PH_RELEASE: if (bus_gnt_i) state <= PH_READ;
            PH_READ:    state <= PH_WRITE;
            PH_WRITE: begin
               size_rem <= size_rem - SZ_ONE;
               state    <= (size_rem == SZ_ONE) ? PH_DEAD : PH_READ;
            end
            PH_DEAD: begin
               state   <= PH_IDLE;
               blk_rem <= blk_rem - CNT_ONE;
               if (blk_rem == CNT_ONE) begin
                  ch_en  <= 1'b0;
                  done_q <= 1'b1;
               end
            end
            default: state <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lvl_dma_seq.sv
module lvl_dma_seq
   import lds_pkg::*;
#(
   parameter int AW          = 16,
   parameter int SZ_W        = 8,
   parameter int CNT_W       = 8,
   parameter int UNIT        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic [AW-1:0]    cfg_src,
   input  logic [AW-1:0]    cfg_dst,
   input  logic [SZ_W-1:0]  cfg_size,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             dreq_n,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic [2:0]       phase,
   output logic             rd_stb,
   output logic             wr_stb,
   output logic [AW-1:0]    addr,
   output logic             busy,
   output logic             done
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("lvl_dma_seq: AW too small");
      end
   endgenerate

   logic    lvl_n, pend, open, act, load;
   phase_e  ph;
   logic [AW-1:0] src_q, dst_q;

   lds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(dreq_n), .dout(lvl_n));

   lds_accept u_accept (
      .clk(clk), .rst_n(rst_n), .open_i(open), .lvl_n_i(lvl_n),
      .act_i(act), .pend_o(pend));

   lds_fsm #(.SZ_W(SZ_W), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .cfg_size_i(cfg_size),
      .cfg_count_i(cfg_count), .pend_i(pend), .bus_gnt_i(bus_gnt),
      .phase_o(ph), .load_o(load), .open_o(open), .act_o(act),
      .busy_o(busy), .done_o(done));

   lds_ptrs #(.AW(AW), .UNIT(UNIT)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .load_i(load), .src_base_i(cfg_src),
      .dst_base_i(cfg_dst), .rd_i(rd_stb), .wr_i(wr_stb),
      .src_o(src_q), .dst_o(dst_q));

   assign phase   = ph;
   assign rd_stb  = (ph == PH_READ);
   assign wr_stb  = (ph == PH_WRITE);
   assign bus_req = (ph != PH_IDLE);
   assign addr    = rd_stb ? src_q : dst_q;

   a_r1_sample_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(busy));
   a_r3_clear_on_activation: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !pend);
   a_r5_closed_while_active: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE) |-> !pend);
   a_r7_release_from_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(pend));
   a_r4_dead_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DEAD) |-> $past(ph) == PH_WRITE);
   a_r8_wait_for_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RELEASE && !bus_gnt) |=> (ph == PH_RELEASE));
   a_r9_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(ph) == PH_DEAD));
   a_r9_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ph == PH_IDLE));
endmodule

// File: tb/lvl_dma_seq_tb.sv
module lvl_dma_seq_tb;
   localparam int AW = 16, SZ_W = 8, CNT_W = 8, UNIT = 2;

   logic clk = 1'b0, rst_n = 1'b0, en_wr = 1'b0, bus_gnt = 1'b0;
   logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
   logic [SZ_W-1:0] cfg_size = '0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic dir_pin = 1'b1, rnd_mode = 1'b0, rnd_bit = 1'b1;
   logic dreq_n, bus_req, rd_stb, wr_stb, busy, done;
   logic [2:0] phase;
   logic [AW-1:0] addr;

   int errs = 0, checks = 0;
   int gnt_max = 0, gnt_wait = 0;
   logic [AW-1:0] exp_src = '0, exp_dst = '0;
   int n_rd = 0, n_wr = 0, n_dead = 0, n_done = 0, blk_rd = 0, cur_size = 1;

   always #10 clk = ~clk;
   assign dreq_n = rnd_mode ? rnd_bit : dir_pin;

   lvl_dma_seq #(.AW(AW), .SZ_W(SZ_W), .CNT_W(CNT_W), .UNIT(UNIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_size(cfg_size), .cfg_count(cfg_count), .dreq_n(dreq_n), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .phase(phase), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .addr(addr), .busy(busy), .done(done));

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] addr_after(logic [AW-1:0] base, int n);
      return base + AW'(n * UNIT);
   endfunction

   always @(negedge clk) begin
      rnd_bit <= 1'($urandom_range(1, 0));
      if (!rst_n || !bus_req) begin
         bus_gnt <= 1'b0;
         gnt_wait <= (gnt_max == 0) ? 0 : $urandom_range(gnt_max, 0);
      end else if (!bus_gnt) begin
         if (gnt_wait <= 0) bus_gnt <= 1'b1;
         else gnt_wait <= gnt_wait - 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_stb) begin chk("R6", "source addr", addr, exp_src); exp_src += AW'(UNIT); n_rd++; blk_rd++; end
         if (wr_stb) begin chk("R6", "dest addr", addr, exp_dst); exp_dst += AW'(UNIT); n_wr++; end
         if (phase == 3'd4) begin chk("R4", "reads in block", blk_rd, cur_size); blk_rd = 0; n_dead++; end
         if (done) n_done++;
      end
   end

   task automatic start(logic [AW-1:0] s, logic [AW-1:0] d, int sz, int cnt);
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_size = SZ_W'(sz); cfg_count = CNT_W'(cnt);
      exp_src = s; exp_dst = d; cur_size = sz;
      n_rd = 0; n_wr = 0; n_dead = 0; n_done = 0; blk_rd = 0;
      en_wr = 1'b1;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   task automatic wait_done(int lim);
      for (int i = 0; i < lim && n_done == 0; i++) @(negedge clk);
   endtask

   task automatic finish_check(logic [AW-1:0] s, logic [AW-1:0] d, int sz, int cnt);
      chk("R9", "done pulses", n_done, 1);
      chk("R9", "dead phases", n_dead, cnt);
      chk("R4", "reads total", n_rd, sz * cnt);
      chk("R4", "writes total", n_wr, sz * cnt);
      chk("R6", "final source", exp_src, addr_after(s, sz * cnt));
      chk("R6", "final dest", exp_dst, addr_after(d, sz * cnt));
      chk("R9", "busy after end", busy, 0);
      rnd_mode = 1'b0; dir_pin = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9", "no block after end", n_dead, cnt);
      chk("R8", "bus_req after end", bus_req, 0);
      dir_pin = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int ph_seen [4];
      int gap;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk("R11", "reset phase", phase, 0);
      chk("R11", "reset bus_req", bus_req, 0);
      chk("R11", "reset strobes", {rd_stb, wr_stb}, 0);
      chk("R11", "reset busy/done", {busy, done}, 0);
      rst_n = 1'b1;

      // R10: zero count or zero size strobes are ignored
      dir_pin = 1'b0;
      start(16'h0100, 16'h0200, 3, 0);
      repeat (6) @(negedge clk);
      chk("R10", "zero count ignored busy", busy, 0);
      chk("R10", "zero count no phase", phase, 0);
      start(16'h0100, 16'h0200, 0, 2);
      repeat (6) @(negedge clk);
      chk("R10", "zero size ignored busy", busy, 0);

      // R1/R7/R8: first read on the third cycle after the enable edge
      gnt_max = 0;
      start(16'h1000, 16'h2000, 2, 3);
      ph_seen[0] = 0;
      for (int n = 1; n <= 3; n++) begin
         @(negedge clk);
         ph_seen[n] = phase;
         if (n == 2) chk("R8", "bus_req in release", bus_req, 1);
      end
      chk("R1", "phase 1 after enable", ph_seen[1], 0);
      chk("R7", "phase 2 after enable", ph_seen[2], 1);
      chk("R1", "phase 3 after enable", ph_seen[3], 2);
      // R5: held-low pin, dead to next read exactly 4 cycles
      while (phase != 3'd4) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (phase != 3'd2 && gap < 20);
      chk("R5", "dead to next read gap", gap, 4);
      wait_done(200);
      finish_check(16'h1000, 16'h2000, 2, 3);

      // R2/R5/R10: high pin idle, short pulse inside transfer ignored
      start(16'h3000, 16'h4000, 4, 2);
      repeat (15) @(negedge clk);
      chk("R2", "high pin no activity", phase, 0);
      chk("R8", "no bus_req while high", bus_req, 0);
      dir_pin = 1'b0; repeat (3) @(negedge clk); dir_pin = 1'b1;
      for (int i = 0; i < 12 && !rd_stb; i++) @(negedge clk);
      chk("R2", "low pulse starts block", rd_stb, 1);
      cfg_src = 16'h7700; cfg_size = 8'd9; en_wr = 1'b1;
      dir_pin = 1'b0;
      @(negedge clk); en_wr = 1'b0;
      @(negedge clk); dir_pin = 1'b1;
      repeat (30) @(negedge clk);
      chk("R5", "pulse during transfer ignored", n_dead, 1);
      chk("R5", "idle after single block", phase, 0);
      chk("R10", "busy kept through re-strobe", busy, 1);
      dir_pin = 1'b0; repeat (3) @(negedge clk); dir_pin = 1'b1;
      wait_done(200);
      finish_check(16'h3000, 16'h4000, 4, 2);

      // random runs with random pin levels and grant delays
      for (int it = 0; it < 14; it++) begin
         int sz, cnt;
         logic [AW-1:0] s, d;
         sz = $urandom_range(5, 1); cnt = $urandom_range(4, 1);
         s = AW'($urandom); d = AW'($urandom);
         gnt_max = $urandom_range(3, 0);
         rnd_mode = 1'b1;
         start(s, d, sz, cnt);
         wait_done(3000);
         finish_check(s, d, sz, cnt);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule